// File: doc/BRIEF.md
# Link-Up Stability Qualifier

This block takes a raw link-good indication and only reports the link as up after that indication has stayed high without a break for a selectable qualification time. Time is measured in pulses of a free-running one-microsecond tick. A 3-bit period code picks one of eight non-linear qualification times, from instantaneous up to two seconds. The raw signal dropping takes the qualified flag down at once, in the same cycle, with no filtering.

The period code is captured only while the raw link is low. A code change during qualification, or while the link is up, therefore does not move the target. Reset loads a default code of 2 (1 ms), so a link that is already good when reset is released is qualified against the default. The parameter `TIME_DIV` divides every table entry by an integer. With the default of 1 the table is in microsecond ticks. Larger values shorten every entry by the same factor, for example to make long settings reachable in short runs.

Top module: `link_stability_qualifier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `link_up` is 0. Asserting reset while the link is qualified forces `link_up` to 0.
- R2: The period code selects the target tick count as follows, each value divided by `TIME_DIV`: code 0 = 0, code 1 = 500, code 2 = 1000, code 3 = 64000, code 4 = 256000, code 5 = 512000, code 6 = 1000000, code 7 = 2000000.
- R3: With `link_raw` high, `link_up` rises at the first clock edge at which at least the target number of ticks has already been counted.
  - A tick is counted when it is high at a clock edge at which `link_raw` is also high.
  - Counting starts at the edge where `link_raw` is first sampled high.
- R4: With code 0, `link_up` rises at the first clock edge at which `link_raw` is sampled high, which is a single register stage.
- R5: If `link_raw` is sampled low at any edge during qualification, the tick count returns to zero and qualification restarts from nothing.
- R6: `link_up` goes low in the same cycle as `link_raw` goes low, before the next clock edge.
- R7: Clock edges at which `tick` is low add nothing to the count.
- R8: `period_code` is loaded at every edge at which `link_raw` is low and is ignored while `link_raw` is high. Reset sets the held code to 2, so a link that is high from reset is qualified against 1000/`TIME_DIV` ticks, whatever `period_code` is.
- R9: The count saturates at the target, and `link_up` stays high for as long as `link_raw` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_raw | input | 1 | Unqualified link-good indication, synchronous to clk |
| tick | input | 1 | One-cycle pulse per microsecond |
| period_code | input | 3 | Qualification period selector, 0 to 7 |
| link_up | output | 1 | Qualified link-up flag |

## Verification
The hardest cases to reach are the long table entries and the way the held code interacts with reset. The bench builds the block with `TIME_DIV` = 100, so every code, including the 2-second one, completes inside the run. It also holds `link_raw` high through reset release with `period_code` at 7, which shows that the default code 2 is the one used. For the rise time, a model in the bench counts the ticks it drives at each edge. It predicts `link_up` edge by edge, including when ticks are sparse, when the raw signal drops in the middle of qualification, and when the code changes after qualification has begun.

// File: rtl/link_stability_qualifier.sv
module link_stability_qualifier #(
  parameter int         TIME_DIV     = 1,
  parameter logic [2:0] DEFAULT_CODE = 3'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_raw,
  input  logic       tick,
  input  logic [2:0] period_code,
  output logic       link_up
);

  localparam int MAX_TICKS = 2000000 / TIME_DIV;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  localparam logic [CNT_W-1:0] T_C0 = '0;
  localparam logic [CNT_W-1:0] T_C1 = CNT_W'(500 / TIME_DIV);
  localparam logic [CNT_W-1:0] T_C2 = CNT_W'(1000 / TIME_DIV);
  localparam logic [CNT_W-1:0] T_C3 = CNT_W'(64000 / TIME_DIV);
  localparam logic [CNT_W-1:0] T_C4 = CNT_W'(256000 / TIME_DIV);
  localparam logic [CNT_W-1:0] T_C5 = CNT_W'(512000 / TIME_DIV);
  localparam logic [CNT_W-1:0] T_C6 = CNT_W'(1000000 / TIME_DIV);
  localparam logic [CNT_W-1:0] T_C7 = CNT_W'(MAX_TICKS);

  logic [2:0]       code_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;
  logic             reached;
  logic             up_q;

  always_comb begin
    case (code_q)
      3'd0:    target = T_C0;
      3'd1:    target = T_C1;
      3'd2:    target = T_C2;
      3'd3:    target = T_C3;
      3'd4:    target = T_C4;
      3'd5:    target = T_C5;
      3'd6:    target = T_C6;
      default: target = T_C7;
    endcase
  end

  assign reached = cnt_q >= target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= DEFAULT_CODE;
      cnt_q  <= '0;
      up_q   <= 1'b0;
    end else if (!link_raw) begin
      code_q <= period_code;
      cnt_q  <= '0;
      up_q   <= 1'b0;
    end else begin
      if (tick && !reached) cnt_q <= cnt_q + 1'b1;
      up_q <= reached;
    end
  end

  assign link_up = up_q & link_raw;

endmodule

// File: rtl/link_stability_qualifier_chk.sv
module link_stability_qualifier_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_raw,
  input logic             link_up,
  input logic [2:0]       code_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] target
);

  assert_down_with_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !link_raw |-> !link_up);

  assert_rise_needs_stable_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(link_raw));

  assert_up_only_when_reached_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (cnt_q >= target));

  assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= target);

  assert_code_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(link_raw) |-> $stable(code_q));

  assert_restart_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(link_raw) |-> (cnt_q == '0));

  assert_count_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(link_raw) |-> (cnt_q >= $past(cnt_q)));

endmodule

bind link_stability_qualifier link_stability_qualifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .link_raw (link_raw),
  .link_up  (link_up),
  .code_q   (code_q),
  .cnt_q    (cnt_q),
  .target   (target)
);

// File: tb/link_stability_qualifier_test.sv
module link_stability_qualifier_test;

  localparam int DIV = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_raw = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] period_code = 3'd0;
  logic       link_up;

  int errors = 0;
  int checks = 0;
  int tick_period = 1;
  int tick_phase = 0;

  always #4 clk = ~clk;

  link_stability_qualifier #(.TIME_DIV(DIV)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_raw    (link_raw),
    .tick        (tick),
    .period_code (period_code),
    .link_up     (link_up)
  );

  // tick pattern, updated 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    tick_phase = (tick_phase + 1 >= tick_period) ? 0 : tick_phase + 1;
    tick = (tick_phase == 0);
  end

  function automatic int table_ticks(input int code);
    case (code)
      0: return 0;
      1: return 500 / DIV;
      2: return 1000 / DIV;
      3: return 64000 / DIV;
      4: return 256000 / DIV;
      5: return 512000 / DIV;
      6: return 1000000 / DIV;
      default: return 2000000 / DIV;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: link_up=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // edge-by-edge model of the count; one check per run
  task automatic run_qual(input string req, input int target, input int n_edges);
    int  seen = 0;
    bit  bad = 0;
    logic exp_v = 1'b0;
    logic act_v = 1'b0;
    for (int e = 0; e < n_edges; e++) begin
      logic exp_now;
      exp_now = (seen >= target) & link_raw;
      if (tick && link_raw && seen < target) seen++;
      step(1);
      if (!bad && link_up !== exp_now) begin
        bad = 1; exp_v = exp_now; act_v = link_up;
      end
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: link_up=%0b expected %0b (target %0d)", req, act_v, exp_v, target);
    end
  endtask

  task automatic prep_code(input logic [2:0] c);
    link_raw = 1'b0;
    period_code = c;
    step(2);
  endtask

  task automatic t_reset_state;
    check("R1 in reset", link_up, 1'b0);
    link_raw = 1'b1;
    period_code = 3'd7;
    step(1);
    check("R1 raw high in reset", link_up, 1'b0);
    rst_n = 1'b1;
    check("R1 first cycle after release", link_up, 1'b0);
  endtask

  task automatic t_default_code;
    // raw high since reset, input code 7 ignored: default code 2 applies
    run_qual("R8 default code after reset", table_ticks(2), table_ticks(2) + 4);
  endtask

  task automatic t_all_codes;
    for (int c = 0; c < 8; c++) begin
      prep_code(3'(c));
      link_raw = 1'b1;
      if (c == 0) run_qual("R4 code 0 single stage", 0, 3);
      else        run_qual("R2 R3 code table timing", table_ticks(c), table_ticks(c) + 3);
    end
  endtask

  task automatic t_fall_same_cycle;
    prep_code(3'd1);
    link_raw = 1'b1;
    step(table_ticks(1) + 2);
    check("R6 up before drop", link_up, 1'b1);
    link_raw = 1'b0;
    #1;
    check("R6 same-cycle deassert", link_up, 1'b0);
    step(1);
    check("R6 stays low", link_up, 1'b0);
  endtask

  task automatic t_restart;
    prep_code(3'd1);
    link_raw = 1'b1;
    run_qual("R5 partial qualification", table_ticks(1), 3);
    link_raw = 1'b0;
    step(1);
    link_raw = 1'b1;
    run_qual("R5 restart from zero", table_ticks(1), table_ticks(1) + 4);
  endtask

  task automatic t_sparse_ticks;
    tick_period = 3;
    prep_code(3'd1);
    link_raw = 1'b1;
    run_qual("R7 sparse ticks", table_ticks(1), 3 * table_ticks(1) + 6);
    tick_period = 1;
    step(3);
  endtask

  task automatic t_code_change_ignored;
    prep_code(3'd1);
    link_raw = 1'b1;
    period_code = 3'd7;
    run_qual("R8 code change while high ignored", table_ticks(1), table_ticks(1) + 4);
  endtask

  task automatic t_hold;
    prep_code(3'd2);
    link_raw = 1'b1;
    run_qual("R9 long hold stays up", table_ticks(2), table_ticks(2) + 200);
    check("R9 still up", link_up, 1'b1);
  endtask

  task automatic t_reset_while_up;
    rst_n = 1'b0;
    #1;
    check("R1 reset while up", link_up, 1'b0);
    step(2);
    rst_n = 1'b1;
    check("R1 after reset release", link_up, 1'b0);
    step(1);
  endtask

  initial begin
    step(1);
    t_reset_state();
    t_default_code();
    t_all_codes();
    t_fall_same_cycle();
    t_restart();
    t_sparse_ticks();
    t_code_change_ignored();
    t_hold();
    t_reset_while_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule